// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block is the transmit half of an asynchronous serial port. A host writes a control byte, a three-bit format selection and a data word through a small write-only register port. The block moves the data word out of a one-entry holding buffer into a shift register and sends it on `txd`, least significant bit first. Each frame has one low start bit, the data bits, an optional parity bit and one high stop bit. Every bit lasts sixteen pulses of the externally generated `baud_tick`.

The frame is always 10 or 11 bits long, chosen by a long-word bit. When parity is on, the parity bit takes the place of the highest data bit, so the frame does not grow. The block can also send a break character. It reports two flags, holding buffer empty and transmission complete, and gates each with its own enable bit in the control byte to produce two interrupt requests. Clearing the transmitter enable lets the frame in progress finish and then holds the line high.

Top module: `sftx_top`

## Requirements
- R1: After reset, `ctrl_out` and `fmt_out` are 0, `txd` is 1, `flag_empty` and `flag_done` are 1, and both interrupt outputs are 0.
- R2: A frame is one start bit at 0, then the payload bits LSB first, then one stop bit at 1. Each bit lasts 16 `baud_tick` pulses. The start bit begins the clock after the buffer is taken. The frame is 10 bits when format bit 2 is 0 and 11 bits when it is 1.
- R3: With parity off (format bit 1 = 0), the frame carries data bits [7:0] when format bit 2 is 0, and data bits [8:0] when format bit 2 is 1.
- R4: With parity on (format bit 1 = 1), the frame carries data bits [6:0] (format bit 2 = 0) or [7:0] (format bit 2 = 1), and then a parity bit just before the stop bit. With format bit 0 = 0 the parity bit makes the count of ones in data plus parity even; with format bit 0 = 1 it makes that count odd.
- R5: With parity off, format bit 0 has no effect on the line.
- R6: Writing address 0 loads the control byte, read back on `ctrl_out`. Bit 7 is the buffer-empty interrupt enable, 6 the complete interrupt enable, 5 and 4 are receive-side enables (stored only), 3 the transmitter enable, 2 and 1 are receive-side controls (stored only), and 0 is send break. Address 1 loads the format from `wr_data[2:0]`. Address 2 loads the data word from `wr_data[8:0]`. Address 3 is ignored.
- R7: `irq_tx` is 1 exactly when `flag_empty` and control bit 7 are both 1. `irq_tc` is 1 exactly when `flag_done` and control bit 6 are both 1.
- R8: A data write clears `flag_empty`. It sets again in the clock where the shifter takes the word.
- R9: A data write clears `flag_done`. It sets when a stop bit ends while the buffer is empty, and stays 0 if a word is waiting at that moment.
- R10: With control bits 3 and 0 set while the shifter is idle, `txd` goes low for one full frame length (10 or 11 bit times). It then stays high for at least one bit time. A break does not change either flag.
- R11: With control bit 3 at 0, no new frame or break starts and the buffer is kept. A frame already in progress when the bit clears is completed.
- R12: When a word is waiting at the end of a stop bit, its start bit begins two clocks after the end of that stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 format, 2 data |
| wr_data | input | 9 | Write data |
| txd | output | 1 | Serial line, idle high |
| ctrl_out | output | 8 | Control byte readback |
| fmt_out | output | 3 | Format readback: [2] long word, [1] parity on, [0] odd parity |
| flag_empty | output | 1 | Holding buffer empty |
| flag_done | output | 1 | Transmission complete |
| irq_tx | output | 1 | Buffer-empty interrupt request |
| irq_tc | output | 1 | Transmission-complete interrupt request |

## Verification
The line is compared on every clock against a behavioural model for all six format codes, using data words with ones near the top boundary. This separates a misplaced parity bit, a wrong data-bit count and a wrong parity sense. The odd-parity bit is also toggled with parity off, to show it has no effect. A run with `baud_tick` on only one clock in three checks that bit time comes from ticks, not from clocks. Back-to-back writes show that the complete flag stays low while a word is waiting. A break, a mid-frame disable and a re-enable check the line-level timing of those controls.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_BRK  = 2'd2,
    ST_MARK = 2'd3
  } sftx_st_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FMT  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CB_IE_EMPTY = 7;
  localparam int CB_IE_DONE  = 6;
  localparam int CB_TX_EN    = 3;
  localparam int CB_BRK      = 0;

  localparam int FB_ODD  = 0;
  localparam int FB_PAR  = 1;
  localparam int FB_LONG = 2;
endpackage

// File: rtl/sftx_regs.sv
module sftx_regs
  import sftx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  input  logic          frame_end,
  output logic [7:0]    ctrl,
  output logic [2:0]    fmt,
  output logic [DW-1:0] tbuf,
  output logic          buf_full,
  output logic          tc
);
  logic [7:0]    ctrl_n;
  logic [2:0]    fmt_n;
  logic [DW-1:0] tbuf_n;
  logic          full_n, tc_n;
  logic          wr_data_sel;

  assign wr_data_sel = wr_en && (wr_addr == ADDR_DATA);

  always_comb begin
    ctrl_n = ctrl;
    fmt_n  = fmt;
    tbuf_n = tbuf;
    full_n = buf_full;
    tc_n   = tc;
    if (load)                   full_n = 1'b0;
    if (frame_end && !buf_full) tc_n   = 1'b1;
    if (wr_en && wr_addr == ADDR_CTRL) ctrl_n = wr_data[7:0];
    if (wr_en && wr_addr == ADDR_FMT)  fmt_n  = wr_data[2:0];
    if (wr_data_sel) begin
      tbuf_n = wr_data;
      full_n = 1'b1;
      tc_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      fmt      <= '0;
      tbuf     <= '0;
      buf_full <= 1'b0;
      tc       <= 1'b1;
    end else begin
      ctrl     <= ctrl_n;
      fmt      <= fmt_n;
      tbuf     <= tbuf_n;
      buf_full <= full_n;
      tc       <= tc_n;
    end
  end
endmodule

// File: rtl/sftx_framer.sv
module sftx_framer
  import sftx_pkg::*;
#(
  parameter int DW = 9,
  parameter int FW = DW + 2
) (
  input  logic [DW-1:0] data,
  input  logic [2:0]    fmt,
  output logic [FW-1:0] frame,
  output logic [3:0]    len
);
  int   nd;
  logic par;

  always_comb begin
    nd  = fmt[FB_LONG] ? DW : DW - 1;
    if (fmt[FB_PAR]) nd = nd - 1;
    par = fmt[FB_ODD];
    for (int i = 0; i < DW; i++)
      if (i < nd) par = par ^ data[i];
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nd)                        frame[i+1] = data[i];
      else if (i == nd && fmt[FB_PAR])   frame[i+1] = par;
    end
    len = fmt[FB_LONG] ? 4'(FW) : 4'(FW - 1);
  end
endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
  import sftx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int FW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic          brk,
  input  logic          buf_full,
  input  logic [FW-1:0] frame,
  input  logic [3:0]    len,
  output logic          txd,
  output logic          load,
  output logic          frame_end
);
  localparam int SUBW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OVS - 1);

  sftx_st_e      st, st_n;
  logic [SUBW-1:0] sub, sub_n;
  logic [3:0]    left, left_n;
  logic [FW-1:0] sh, sh_n;
  logic          bit_end;

  assign bit_end = baud_tick && (sub == SUB_LAST);

  always_comb begin
    st_n      = st;
    sub_n     = sub;
    left_n    = left;
    sh_n      = sh;
    load      = 1'b0;
    frame_end = 1'b0;
    if (st != ST_IDLE && baud_tick)
      sub_n = bit_end ? '0 : sub + 1'b1;
    unique case (st)
      ST_IDLE: begin
        if (tx_en && brk) begin
          st_n   = ST_BRK;
          left_n = len;
          sub_n  = '0;
        end else if (tx_en && buf_full) begin
          st_n   = ST_SEND;
          left_n = len;
          sh_n   = frame;
          sub_n  = '0;
          load   = 1'b1;
        end
      end
      ST_SEND: if (bit_end) begin
        sh_n   = {1'b1, sh[FW-1:1]};
        left_n = left - 1'b1;
        if (left == 4'd1) begin
          st_n      = ST_IDLE;
          frame_end = 1'b1;
        end
      end
      ST_BRK: if (bit_end) begin
        left_n = left - 1'b1;
        if (left == 4'd1) st_n = ST_MARK;
      end
      ST_MARK: if (bit_end) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sub  <= '0;
      left <= '0;
      sh   <= '1;
    end else begin
      st   <= st_n;
      sub  <= sub_n;
      left <= left_n;
      sh   <= sh_n;
    end
  end

  assign txd = (st == ST_SEND) ? sh[0] : (st != ST_BRK);
endmodule

// File: rtl/sftx_top.sv
module sftx_top
  import sftx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic [7:0]    ctrl_out,
  output logic [2:0]    fmt_out,
  output logic          flag_empty,
  output logic          flag_done,
  output logic          irq_tx,
  output logic          irq_tc
);
  localparam int FW = DW + 2;

  logic [DW-1:0] tbuf;
  logic [FW-1:0] frame;
  logic [3:0]    len;
  logic          buf_full, tc, load, frame_end;

  sftx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .frame_end(frame_end),
    .ctrl(ctrl_out), .fmt(fmt_out), .tbuf(tbuf),
    .buf_full(buf_full), .tc(tc)
  );

  sftx_framer #(.DW(DW), .FW(FW)) u_framer (
    .data(tbuf), .fmt(fmt_out), .frame(frame), .len(len)
  );

  sftx_shifter #(.OVS(OVS), .FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .tx_en(ctrl_out[CB_TX_EN]), .brk(ctrl_out[CB_BRK]),
    .buf_full(buf_full), .frame(frame), .len(len),
    .txd(txd), .load(load), .frame_end(frame_end)
  );

  assign flag_empty = !buf_full;
  assign flag_done  = tc;
  assign irq_tx     = flag_empty && ctrl_out[CB_IE_EMPTY];
  assign irq_tc     = flag_done && ctrl_out[CB_IE_DONE];
endmodule

// File: rtl/sftx_chk.sv
module sftx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       txd,
  input logic [7:0] ctrl_out,
  input logic       flag_empty,
  input logic       flag_done,
  input logic       load,
  input logic       frame_end
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> txd); // R2
  AST_EMPTY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_empty) |-> $past(load)); // R8
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (!flag_empty && !flag_done)); // R9
  AST_DONE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> ($past(frame_end) && $past(flag_empty))); // R9
  AST_TAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ctrl_out[3]); // R11
endmodule

bind sftx_top sftx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .txd(txd), .ctrl_out(ctrl_out), .flag_empty(flag_empty),
  .flag_done(flag_done), .load(load), .frame_end(frame_end)
);

// File: tb/sim_sftx_top.sv
module sim_sftx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [8:0] wr_data = 9'd0;
  logic       txd, flag_empty, flag_done, irq_tx, irq_tc;
  logic [7:0] ctrl_out;
  logic [2:0] fmt_out;

  int checks = 0, errors = 0, cyc = 0, tdiv = 1, tcnt = 0;
  int run = 0, maxrun = 0;
  string cur = "R1";

  // behavioural reference state
  int   m_mode = 0, m_tk = 0, m_bl = 0;
  bit   m_q[$];
  logic [7:0] m_ctrl = 0;
  logic [2:0] m_fmt = 0;
  logic [8:0] m_buf = 0;
  bit   m_full = 0, m_tc = 1;

  always #2.5 clk = ~clk;

  sftx_top u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .txd(txd), .ctrl_out(ctrl_out),
    .fmt_out(fmt_out), .flag_empty(flag_empty), .flag_done(flag_done),
    .irq_tx(irq_tx), .irq_tc(irq_tc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int flen(input logic [2:0] f);
    return f[2] ? 11 : 10;
  endfunction

  function automatic bit m_txd();
    if (m_mode == 1) return m_q[0];
    return (m_mode != 2);
  endfunction

  // reference model step
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_tk = 0; m_q.delete();
      m_ctrl = 0; m_fmt = 0; m_buf = 0; m_full = 0; m_tc = 1;
    end else begin
      bit fe, ld;
      fe = 0; ld = 0;
      case (m_mode)
        0: if (m_ctrl[3]) begin
          if (m_ctrl[0]) begin m_mode = 2; m_bl = flen(m_fmt); m_tk = 0; end
          else if (m_full) begin
            int nd; bit p;
            nd = (m_fmt[2] ? 9 : 8) - (m_fmt[1] ? 1 : 0);
            p = m_fmt[0];
            m_q.delete();
            m_q.push_back(1'b0);
            for (int i = 0; i < nd; i++) begin
              m_q.push_back(m_buf[i]);
              p = p ^ m_buf[i];
            end
            if (m_fmt[1]) m_q.push_back(p);
            m_q.push_back(1'b1);
            m_mode = 1; m_tk = 0; ld = 1;
          end
        end
        1: if (baud_tick) begin
          m_tk++;
          if (m_tk == 16) begin
            m_tk = 0; void'(m_q.pop_front());
            if (m_q.size() == 0) begin m_mode = 0; fe = 1; end
          end
        end
        2: if (baud_tick) begin
          m_tk++;
          if (m_tk == 16) begin m_tk = 0; m_bl--; if (m_bl == 0) m_mode = 3; end
        end
        default: if (baud_tick) begin
          m_tk++;
          if (m_tk == 16) begin m_tk = 0; m_mode = 0; end
        end
      endcase
      if (ld) m_full = 0;
      if (fe && !m_full) m_tc = 1;
      if (wr_en && wr_addr == 0) m_ctrl = wr_data[7:0];
      if (wr_en && wr_addr == 1) m_fmt = wr_data[2:0];
      if (wr_en && wr_addr == 2) begin m_buf = wr_data; m_full = 1; m_tc = 0; end
    end
  end

  // tick generation, per-cycle comparison, low-run meter, watchdog
  always @(negedge clk) begin
    cyc++;
    tcnt++;
    baud_tick = (tcnt % tdiv) == 0;
    if (rst_n) begin
      chk(txd === m_txd(), {cur, " R2 line"}, txd, m_txd());
      chk(flag_empty === !m_full, {cur, " R8 empty"}, flag_empty, !m_full);
      chk(flag_done === m_tc, {cur, " R9 done"}, flag_done, m_tc);
      chk(irq_tx === (!m_full && m_ctrl[7]) && irq_tc === (m_tc && m_ctrl[6]),
          "R7 irq", {irq_tx, irq_tc}, {!m_full && m_ctrl[7], m_tc && m_ctrl[6]});
      chk(ctrl_out === m_ctrl && fmt_out === m_fmt, "R6 regs",
          {ctrl_out, fmt_out}, {m_ctrl, m_fmt});
      if (txd === 1'b0) run++;
      else begin if (run > maxrun) maxrun = run; run = 0; end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] f, input logic [8:0] d, input string req);
    cur = req;
    wr(2'd1, {6'd0, f});
    wr(2'd2, d);
    idle(11 * 16 * tdiv + 10);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    chk(txd === 1'b1 && flag_empty === 1'b1 && flag_done === 1'b1, "R1 flags/line",
        {txd, flag_empty, flag_done}, 3'b111);
    chk(ctrl_out === 8'h00 && fmt_out === 3'd0 && irq_tx === 1'b0 && irq_tc === 1'b0,
        "R1 regs", {ctrl_out, fmt_out}, 0);
    rst_n = 1'b1;
    idle(2);
    cur = "R6";
    wr(2'd0, 9'h0C8);
    chk(ctrl_out === 8'hC8, "R6 ctrl readback", ctrl_out, 8'hC8);
    chk(irq_tx === 1'b1 && irq_tc === 1'b1, "R7 both irq", {irq_tx, irq_tc}, 2'b11);
    wr(2'd3, 9'h1FF);
    chk(ctrl_out === 8'hC8 && fmt_out === 3'd0, "R6 addr3 ignored", ctrl_out, 8'hC8);
    // format sweep
    send(3'd0, 9'h0A5, "R3 8N");
    send(3'd4, 9'h1A5, "R3 9N");
    send(3'd2, 9'h0B5, "R4 7E");
    send(3'd3, 9'h0B5, "R4 7O");
    send(3'd6, 9'h1C3, "R4 8E");
    send(3'd7, 9'h1C3, "R4 8O");
    send(3'd1, 9'h0A5, "R5 odd ignored 8");
    send(3'd5, 9'h15A, "R5 odd ignored 9");
    // slow ticks
    tdiv = 3;
    send(3'd4, 9'h0F0, "R2 tick paced");
    tdiv = 1;
    // back-to-back
    cur = "R12";
    wr(2'd1, 9'd0);
    wr(2'd2, 9'h055);
    idle(5);
    wr(2'd2, 9'h0AA);
    idle(165);
    chk(flag_done === 1'b0 && flag_empty === 1'b1, "R9 done held while waiting",
        {flag_done, flag_empty}, 2'b01);
    idle(200);
    chk(flag_done === 1'b1, "R9 done after last", flag_done, 1);
    // break
    cur = "R10";
    maxrun = 0;
    wr(2'd0, 9'h0C9);
    idle(30);
    wr(2'd0, 9'h0C8);
    idle(200);
    chk(maxrun == 160, "R10 break length", maxrun, 160);
    chk(flag_done === 1'b1 && flag_empty === 1'b1, "R10 flags kept",
        {flag_done, flag_empty}, 2'b11);
    wr(2'd1, 9'd4);
    maxrun = 0;
    wr(2'd0, 9'h009);
    idle(30);
    wr(2'd0, 9'h008);
    idle(210);
    chk(maxrun == 176, "R10 long break length", maxrun, 176);
    // disable mid-frame
    cur = "R11";
    wr(2'd1, 9'd0);
    wr(2'd2, 9'h000);
    idle(40);
    wr(2'd0, 9'h000);
    idle(150);
    wr(2'd2, 9'h03C);
    idle(300);
    chk(flag_empty === 1'b0 && txd === 1'b1, "R11 held while disabled",
        {flag_empty, txd}, 2'b01);
    wr(2'd0, 9'h008);
    idle(200);
    chk(flag_empty === 1'b1 && flag_done === 1'b1, "R11 sent after enable",
        {flag_empty, flag_done}, 2'b11);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule